// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the configuration front end of a frequency synthesizer. A host drives three wires: a serial clock, a data line and a load enable. Words of 24 bits are shifted in with the most significant bit first. When the load enable rises, the two lowest bits of the word pick which latch takes bits 23..2. There are four targets: the reference-divider latch, the A/B-counter latch, the function latch, and an initialization alias of the function latch.

The block derives the digital control strobes the rest of the synthesizer needs from the latched words:

- a one-cycle internal counter-reset pulse;
- a counter-hold level, which also tells the pump to float;
- the power-down state;
- the charge-pump current code in force.

It also runs the fastlock timer. In timed fastlock mode this timer clears the gain bit of the A/B latch by itself once the programmed number of reference-divider cycles has gone by.

All three serial wires are brought into the system clock domain through flop synchronisers. The serial clock and load enable each get a rising-edge detector, so the host may toggle them far slower than the system clock. The reference-divider tick and the charge-pump event arrive as single-cycle strobes from neighbouring logic.

Top module: `synth_cfg_port`

## Requirements
- R1: Bits are shifted in MSB first on each rising serial-clock edge. A load with select code 00 (word bits 1:0) places word bits 23:2 on `ref_word`.
- R2: Select code 01 writes `ab_word`. Code 10 writes `func_word`. Code 11 also writes `func_word`. A write leaves the other latches unchanged, and all latches reset to zero.
- R3: A write with code 11 raises `rst_pulse` for exactly one cycle, and `cnt_hold` is high in that cycle.
- R4: The first code-01 write after a code-11 write raises `rst_pulse` once. Later code-01 writes and code-10 writes raise no pulse until the next code-11 write.
- R5: While function bit DB2 is 1, `cnt_hold` is high and `pwr_down` stays low.
- R6: `chip_en` low forces `pwr_down` and `cnt_hold` high in the same cycle. Words are still shifted and latched while powered down.
- R7: With function bits DB3 (PD1) = 1 and DB21 (PD2) = 0, `pwr_down` is high right after the write. Writing PD1 = 0 releases it.
- R8: With PD1 = 1 and PD2 = 1 from a code-10 write, `pwr_down` waits for the next `cp_event` strobe. The same bits written with code 11 power down at once.
- R9: `cp_cur` shows function bits DB20:18 when the A/B gain bit DB21 is 1, and bits DB17:15 when it is 0.
- R10: With DB9 = 1 and DB10 = 1 (timed fastlock), an A/B write with gain 1 starts the timer. The gain bit clears after exactly 3 + 4·k `ref_tick` strobes, where k is function bits DB14:11.
- R11: With DB9 = 0, or with DB9 = 1 and DB10 = 0, the gain bit never clears by itself.
- R12: While `cnt_hold` is high, the fastlock timer is held at its full load value, and ticks in that time do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable; rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low powers down immediately |
| cp_event | input | 1 | One-cycle charge-pump event strobe |
| ref_tick | input | 1 | One-cycle strobe per reference-divider cycle |
| ref_word | output | 22 | Reference-divider latch contents |
| ab_word | output | 22 | A/B-counter latch contents, gain bit live |
| func_word | output | 22 | Function latch contents |
| cp_cur | output | 3 | Charge-pump current code in force |
| rst_pulse | output | 1 | One-cycle internal counter-reset pulse |
| cnt_hold | output | 1 | Counters at load state, pump floated |
| pwr_down | output | 1 | Power-down state |

## Verification
The checker assumes the following about the inputs:

- Each serial-clock and load-enable level lasts several system clocks, so every edge is seen exactly once.
- The data line is stable while the serial clock rises.
- A load-enable edge never coincides with a serial-clock edge.
- `cp_event` and `ref_tick` are one-cycle strobes in the system clock domain.

The stimulus meets all of this by holding every serial level for four system clocks, by raising load enable only after the serial clock has returned low, and by pulsing each strobe for a single cycle between idle cycles.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;
    localparam int TC_W   = 4;
    localparam int CS_W   = 3;

    // word bit positions
    localparam int DB_F1      = 2;
    localparam int DB_PD1     = 3;
    localparam int DB_FL_EN   = 9;
    localparam int DB_FL_MODE = 10;
    localparam int DB_TC_LO   = 11;
    localparam int DB_CS1_LO  = 15;
    localparam int DB_CS2_LO  = 18;
    localparam int DB_PD2     = 21;
    localparam int DB_GAIN    = 21;

    // payload bit positions
    localparam int P_F1      = DB_F1 - ADDR_W;
    localparam int P_PD1     = DB_PD1 - ADDR_W;
    localparam int P_FL_EN   = DB_FL_EN - ADDR_W;
    localparam int P_FL_MODE = DB_FL_MODE - ADDR_W;
    localparam int P_TC_LO   = DB_TC_LO - ADDR_W;
    localparam int P_CS1_LO  = DB_CS1_LO - ADDR_W;
    localparam int P_CS2_LO  = DB_CS2_LO - ADDR_W;
    localparam int P_PD2     = DB_PD2 - ADDR_W;
    localparam int P_GAIN    = DB_GAIN - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_AB   = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;

    typedef struct packed {
        logic [PAY_W-1:0] ref_w;
        logic [PAY_W-1:0] ab_w;
        logic [PAY_W-1:0] fn_w;
        logic             arm;
        logic             pulse;
        logic             sync_pd;
    } cfg_state_t;
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_rise_det.sv
`timescale 1ns/1ps
module cfg_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
`timescale 1ns/1ps
module cfg_shift_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift) sr_d = {sr_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;
endmodule

// File: rtl/cfg_fastlock_timer.sv
`timescale 1ns/1ps
module cfg_fastlock_timer #(
    parameter int TCW  = 4,
    parameter int BASE = 3,
    parameter int STEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic           cancel,
    input  logic           hold,
    input  logic           tick,
    input  logic [TCW-1:0] tcode,
    output logic           clr
);
    localparam int MAXT  = BASE + STEP * ((1 << TCW) - 1);
    localparam int CNT_W = $clog2(MAXT + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(BASE) + CNT_W'(STEP) * CNT_W'(tcode);
        st_d  = st_q;
        clr   = 1'b0;
        if (arm) begin
            st_d.run = 1'b1;
            st_d.cnt = limit;
        end else if (cancel) begin
            st_d.run = 1'b0;
        end else if (st_q.run) begin
            if (hold) begin
                st_d.cnt = limit;
            end else if (tick) begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    st_d.run = 1'b0;
                    clr      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/synth_cfg_port.sv
`timescale 1ns/1ps
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMR_BASE    = 3,
    parameter int TMR_STEP    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    input  logic             chip_en,
    input  logic             cp_event,
    input  logic             ref_tick,
    output logic [PAY_W-1:0] ref_word,
    output logic [PAY_W-1:0] ab_word,
    output logic [PAY_W-1:0] func_word,
    output logic [CS_W-1:0]  cp_cur,
    output logic             rst_pulse,
    output logic             cnt_hold,
    output logic             pwr_down
);
    logic [2:0]        raw_in, syn_in;
    logic [1:0]        edges;
    logic              wr_stb, shift_stb;
    logic [WORD_W-1:0] sreg;
    logic [PAY_W-1:0]  pay;
    latch_sel_e        sel;
    logic              ab_wr, mode2, tmr_arm, tmr_cancel, clr_gain;
    cfg_state_t        st_d, st_q;

    assign raw_in = {ser_le, ser_clk, ser_data};

    cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_in)
    );

    cfg_rise_det #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (syn_in[2:1]),
        .rise (edges)
    );

    assign wr_stb    = edges[1];
    assign shift_stb = edges[0] & ~edges[1];

    cfg_shift_reg #(.W(WORD_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .shift(shift_stb),
        .din  (syn_in[0]),
        .word (sreg)
    );

    assign sel = latch_sel_e'(sreg[ADDR_W-1:0]);
    assign pay = sreg[WORD_W-1:ADDR_W];

    // power and hold state from registered contents
    assign pwr_down  = ~chip_en | (st_q.fn_w[P_PD1] & (~st_q.fn_w[P_PD2] | st_q.sync_pd));
    assign cnt_hold  = pwr_down | st_q.fn_w[P_F1] | st_q.pulse;
    assign rst_pulse = st_q.pulse;

    assign ab_wr      = wr_stb && (sel == SEL_AB);
    assign mode2      = st_q.fn_w[P_FL_EN] & st_q.fn_w[P_FL_MODE];
    assign tmr_arm    = ab_wr & pay[P_GAIN] & mode2;
    assign tmr_cancel = ab_wr & ~tmr_arm;

    cfg_fastlock_timer #(.TCW(TC_W), .BASE(TMR_BASE), .STEP(TMR_STEP)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (tmr_arm),
        .cancel(tmr_cancel),
        .hold  (cnt_hold),
        .tick  (ref_tick),
        .tcode (st_q.fn_w[P_TC_LO +: TC_W]),
        .clr   (clr_gain)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clr_gain) st_d.ab_w[P_GAIN] = 1'b0;
        if (cp_event && st_q.fn_w[P_PD1] && st_q.fn_w[P_PD2]) st_d.sync_pd = 1'b1;
        if (wr_stb) begin
            unique case (sel)
                SEL_REF: st_d.ref_w = pay;
                SEL_AB: begin
                    st_d.ab_w = pay;
                    if (st_q.arm) begin
                        st_d.pulse = 1'b1;
                        st_d.arm   = 1'b0;
                    end
                end
                SEL_FUNC: begin
                    st_d.fn_w    = pay;
                    st_d.sync_pd = 1'b0;
                end
                SEL_INIT: begin
                    st_d.fn_w    = pay;
                    st_d.pulse   = 1'b1;
                    st_d.arm     = 1'b1;
                    st_d.sync_pd = pay[P_PD1] & pay[P_PD2];
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_word  = st_q.ref_w;
    assign ab_word   = st_q.ab_w;
    assign func_word = st_q.fn_w;
    assign cp_cur    = st_q.ab_w[P_GAIN] ? st_q.fn_w[P_CS2_LO +: CS_W]
                                         : st_q.fn_w[P_CS1_LO +: CS_W];
endmodule

// File: rtl/synth_cfg_port_chk.sv
`timescale 1ns/1ps
module synth_cfg_port_chk
    import synth_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             chip_en,
    input logic             cp_event,
    input logic             ref_tick,
    input logic             wr_stb,
    input logic             rst_pulse,
    input logic             cnt_hold,
    input logic             pwr_down,
    input logic             ab_gain,
    input logic [PAY_W-1:0] ref_word,
    input logic [PAY_W-1:0] func_word
);
    // R2
    latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> ($stable(ref_word) && $stable(func_word)));

    // R3
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(wr_stb));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R5
    reset_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        func_word[P_F1] |-> cnt_hold);

    // R6
    chip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (pwr_down && cnt_hold));

    // R8
    pd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> (!chip_en || $past(wr_stb) || $past(cp_event)));

    // R10
    gain_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ab_gain) |-> ($past(wr_stb) || $past(ref_tick)));
endmodule

bind synth_cfg_port synth_cfg_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .cp_event (cp_event),
    .ref_tick (ref_tick),
    .wr_stb   (wr_stb),
    .rst_pulse(rst_pulse),
    .cnt_hold (cnt_hold),
    .pwr_down (pwr_down),
    .ab_gain  (ab_word[synth_cfg_pkg::P_GAIN]),
    .ref_word (ref_word),
    .func_word(func_word)
);

// File: tb/synth_cfg_port_tb.sv
`timescale 1ns/1ps
module synth_cfg_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic chip_en = 1'b1, cp_event = 1'b0, ref_tick = 1'b0;
    logic [21:0] ref_word, ab_word, func_word;
    logic [2:0]  cp_cur;
    logic        rst_pulse, cnt_hold, pwr_down;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int holds = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    synth_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .chip_en(chip_en), .cp_event(cp_event),
        .ref_tick(ref_tick), .ref_word(ref_word), .ab_word(ab_word),
        .func_word(func_word), .cp_cur(cp_cur), .rst_pulse(rst_pulse),
        .cnt_hold(cnt_hold), .pwr_down(pwr_down)
    );

    always @(posedge clk) begin
        if (rst_pulse) pulses <= pulses + 1;
        if (cnt_hold)  holds  <= holds + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            ser_data = w[i];
            clocks(4);
            ser_clk = 1'b1;
            clocks(4);
            ser_clk = 1'b0;
        end
        clocks(4);
        ser_le = 1'b1;
        clocks(4);
        ser_le = 1'b0;
        clocks(6);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
        end
    endtask

    function automatic logic [23:0] fw(input logic f1, input logic pd1, input logic pd2,
                                       input logic fen, input logic fmode, input logic [3:0] k,
                                       input logic [2:0] s1, input logic [2:0] s2,
                                       input logic [1:0] code);
        logic [23:0] w;
        w = '0;
        w[1:0]   = code;
        w[2]     = f1;
        w[3]     = pd1;
        w[9]     = fen;
        w[10]    = fmode;
        w[14:11] = k;
        w[17:15] = s1;
        w[20:18] = s2;
        w[21]    = pd2;
        return w;
    endfunction

    function automatic logic [23:0] abw(input logic gain, input logic [21:0] val);
        logic [21:0] p;
        p = val;
        p[19] = gain;
        return {p, 2'b01};
    endfunction

    initial begin
        int p0, h0, t;
        logic [23:0] w;
        clocks(4);
        rst_n = 1'b1;
        clocks(2);
        // reset state (R2)
        check("R2 reset ref", 32'(ref_word), 0);
        check("R2 reset ab", 32'(ab_word), 0);
        check("R2 reset func", 32'(func_word), 0);
        check("R2 reset pwr_down", 32'(pwr_down), 0);
        check("R2 reset cnt_hold", 32'(cnt_hold), 0);

        // R1 walking ones into reference latch
        for (int b = 0; b < 22; b++) begin
            w = {22'(1) << b, 2'b00};
            send(w);
            check("R1 walking one", 32'(ref_word), 32'(w[23:2]));
        end
        send({22'h2A5C3B, 2'b00});
        check("R1 pattern", 32'(ref_word), 32'h2A5C3B);

        // R2 A/B and function writes leave others alone
        p0 = pulses;
        send(abw(1'b0, 22'h025A5A));
        check("R2 ab write", 32'(ab_word), 32'h025A5A);
        check("R2 ref untouched", 32'(ref_word), 32'h2A5C3B);
        w = fw(0, 0, 0, 0, 0, 4'd6, 3'd3, 3'd6, 2'b10);
        send(w);
        check("R2 func write", 32'(func_word), 32'(w[23:2]));
        check("R2 ab untouched", 32'(ab_word), 32'h025A5A);
        check("R4 no pulse without init", 32'(pulses - p0), 0);

        // R3 init write
        p0 = pulses; h0 = holds;
        w = fw(0, 0, 0, 1, 0, 4'd0, 3'd5, 3'd2, 2'b11);
        send(w);
        check("R3 init updates func", 32'(func_word), 32'(w[23:2]));
        check("R3 one pulse", 32'(pulses - p0), 1);
        check("R3 one hold cycle", 32'(holds - h0), 1);
        check("R3 ref untouched", 32'(ref_word), 32'h2A5C3B);

        // R4 first A/B load pulses, later ones do not
        p0 = pulses;
        send(abw(1'b0, 22'h000123));
        check("R4 first ab pulses", 32'(pulses - p0), 1);
        send(abw(1'b0, 22'h000456));
        check("R4 second ab silent", 32'(pulses - p0), 1);
        send(fw(0, 0, 0, 1, 0, 4'd0, 3'd5, 3'd2, 2'b11));
        check("R4 reinit pulses", 32'(pulses - p0), 2);
        send(fw(0, 0, 0, 1, 0, 4'd0, 3'd5, 3'd2, 2'b10));
        check("R4 func write silent", 32'(pulses - p0), 2);
        send(abw(1'b0, 22'h000789));
        check("R4 ab after reinit pulses", 32'(pulses - p0), 3);
        send(abw(1'b0, 22'h00078A));
        check("R4 ab again silent", 32'(pulses - p0), 3);

        // R5 counter reset bit
        send(fw(1, 0, 0, 1, 0, 4'd0, 3'd5, 3'd2, 2'b10));
        check("R5 hold with reset bit", 32'(cnt_hold), 1);
        check("R5 no power down", 32'(pwr_down), 0);
        send(fw(0, 0, 0, 1, 0, 4'd0, 3'd5, 3'd2, 2'b10));
        check("R5 hold released", 32'(cnt_hold), 0);

        // R9 current selection, R11 mode 1 keeps gain
        send(abw(1'b0, 22'h000010));
        check("R9 setting one", 32'(cp_cur), 5);
        send(abw(1'b1, 22'h000010));
        check("R9 setting two", 32'(cp_cur), 2);
        tick(70);
        check("R11 mode1 gain kept", 32'(ab_word[19]), 1);
        send(fw(0, 0, 0, 0, 1, 4'd0, 3'd1, 3'd7, 2'b10));
        send(abw(1'b1, 22'h000010));
        tick(70);
        check("R11 disabled gain kept", 32'(ab_word[19]), 1);
        check("R9 setting two other code", 32'(cp_cur), 7);

        // R6 chip enable
        chip_en = 1'b0;
        @(negedge clk);
        check("R6 pwr_down on chip_en low", 32'(pwr_down), 1);
        check("R6 hold on chip_en low", 32'(cnt_hold), 1);
        send({22'h1B0D0F, 2'b00});
        check("R6 latch while down", 32'(ref_word), 32'h1B0D0F);
        chip_en = 1'b1;
        @(negedge clk);
        check("R6 released", 32'(pwr_down), 0);

        // R7 asynchronous programmed power-down
        send(fw(0, 1, 0, 0, 0, 4'd0, 3'd1, 3'd7, 2'b10));
        check("R7 immediate power down", 32'(pwr_down), 1);
        send(fw(0, 0, 0, 0, 0, 4'd0, 3'd1, 3'd7, 2'b10));
        check("R7 released", 32'(pwr_down), 0);

        // R8 synchronous power-down
        send(fw(0, 1, 1, 0, 0, 4'd0, 3'd1, 3'd7, 2'b10));
        check("R8 waits for event", 32'(pwr_down), 0);
        clocks(20);
        check("R8 still waiting", 32'(pwr_down), 0);
        @(negedge clk) cp_event = 1'b1;
        @(negedge clk) cp_event = 1'b0;
        check("R8 down after event", 32'(pwr_down), 1);
        send(fw(0, 0, 0, 0, 0, 4'd0, 3'd1, 3'd7, 2'b10));
        check("R8 released", 32'(pwr_down), 0);
        send(fw(0, 1, 1, 0, 0, 4'd0, 3'd1, 3'd7, 2'b11));
        check("R8 init immediate", 32'(pwr_down), 1);
        send(fw(0, 0, 0, 0, 0, 4'd0, 3'd1, 3'd7, 2'b10));
        check("R8 released after init", 32'(pwr_down), 0);

        // R10 timeout sweep over every code
        for (int k = 0; k < 16; k++) begin
            t = 3 + 4 * k;
            send(fw(0, 0, 0, 1, 1, 4'(k), 3'd1, 3'd6, 2'b10));
            send(abw(1'b1, 22'(k)));
            tick(t - 1);
            check("R10 gain before timeout", 32'(ab_word[19]), 1);
            check("R10 current two in fastlock", 32'(cp_cur), 6);
            tick(1);
            check("R10 gain cleared at timeout", 32'(ab_word[19]), 0);
            check("R10 current one after", 32'(cp_cur), 1);
            check("R10 other ab bits kept", 32'(ab_word[5:0]), 32'(k));
        end

        // R12 hold freezes the timer
        send(fw(0, 0, 0, 1, 1, 4'd0, 3'd1, 3'd6, 2'b10));
        send(abw(1'b1, 22'h000001));
        tick(2);
        chip_en = 1'b0;
        clocks(2);
        tick(5);
        check("R12 gain kept while held", 32'(ab_word[19]), 1);
        chip_en = 1'b1;
        clocks(2);
        tick(2);
        check("R12 reloaded count", 32'(ab_word[19]), 1);
        tick(1);
        check("R12 clears after full count", 32'(ab_word[19]), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule